// File: doc/BRIEF.md
# Mechanical Operation Timeout Watchdog

This block guards the mechanical operations of a disk drive. When a seek, an initial head load, a head unload or a recalibrate begins, it opens a timing cycle and counts pulses of a slow tick taken from spindle rotation. A seek gets a short window. The three head-movement operations get a long window. The cycle ends without a fault when the operation's completion indicator arrives. For a seek, a load or a recalibrate that indicator is "heads settled on cylinder". For an unload it is "heads fully retracted".

If the window runs out first, the block latches a fault. The active-low fault output goes low, the fault LED turns on, and a shutdown request asks the surrounding logic to unload the heads, brake the spindle and unlatch the door. While the fault is held, the counter cannot be reset and new operations are ignored. Only the start of the power-on sequence or a move of the run switch to RUN releases it.

Top module: `mech_timeout_wdog`

## Requirements
- R1: After the system reset, fault_n is 1, fault_led is 0 and shutdown_req is 0.
- R2: A seek start (start_seek=1 for one cycle) with no completion declares the fault on exactly the SHORT_TICKS-th tick pulse (default 16). After SHORT_TICKS-1 pulses there is no fault.
- R3: A start from start_load, start_unload or start_recal with no completion declares the fault on exactly the LONG_TICKS-th tick pulse (default 225). After LONG_TICKS-1 pulses there is no fault.
- R4: While a seek, load or recalibrate cycle is running, settled_i=1 ends the cycle. Later tick pulses then produce no fault.
- R5: An unload cycle ends only on retracted_i=1; settled_i has no effect on it. retracted_i has no effect on a seek, load or recalibrate cycle.
- R6: Each tick pulse advances the count once, however many clock cycles tick_in stays high. The count moves on a 0-to-1 change of tick_in.
- R7: With no cycle running, tick pulses never produce a fault.
- R8: A start that arrives while a cycle is running restarts the count from zero, using the window and completion type of the new operation.
- R9: While the fault is held, fault_n=0, fault_led=1 and shutdown_req=1. All three change together.
- R10: Once declared, the fault holds through tick pulses, starts, settled_i and retracted_i until a clear event.
- R11: A clear event clears both the fault and any running cycle. A clear event is por_start=1, or a 0-to-1 change of run_sw. Holding run_sw at 1 does not clear again. After a clear, a new operation is timed normally.
- R12: If several starts arrive in the same cycle, they are ranked seek, then recalibrate, then load, then unload. The highest-ranked one chooses the window and the completion type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| tick_in | input | 1 | Slow spindle-derived timing tick, level |
| start_seek | input | 1 | Seek operation decoded (one-cycle pulse) |
| start_load | input | 1 | Initial head load begins |
| start_unload | input | 1 | Normal head unload begins |
| start_recal | input | 1 | Recalibrate command decoded |
| settled_i | input | 1 | Heads settled on the target cylinder |
| retracted_i | input | 1 | Heads at fully retracted position |
| por_start | input | 1 | Power-on sequence starting (clear) |
| run_sw | input | 1 | Run switch level; a rise to RUN clears |
| fault_n | output | 1 | Timeout fault, active low |
| fault_led | output | 1 | Fault lamp drive, active high |
| shutdown_req | output | 1 | Request to unload heads, brake spindle, unlatch door |

## Verification
The bench stops at the boundary of each window, one pulse short of the limit and then exactly at it. A terminal-count comparison that is off by one would fault a pulse early or a pulse late. It stretches tick pulses over several clocks, which catches a design that counts level instead of edges, because such a design would expire after far fewer pulses. It pairs each operation type with the wrong completion indicator, so a design that lets any completion cancel any cycle would miss the unload fault. It also checks that a held fault survives stimulus, that a held RUN switch does not clear twice, and that simultaneous starts and restarts select the correct window.

// File: rtl/mtw_pkg.sv
package mtw_pkg;

  typedef enum logic {
    AWAIT_SETTLE  = 1'b0,
    AWAIT_RETRACT = 1'b1
  } await_e;

  // Window length in ticks for the chosen operation class
  function automatic int unsigned window_ticks(input logic long_win,
                                               input int unsigned short_t,
                                               input int unsigned long_t);
    return long_win ? long_t : short_t;
  endfunction

  // True when the pending tick brings the count to the terminal value
  function automatic logic hits_terminal(input int unsigned count,
                                         input int unsigned limit);
    return (count + 1) == limit;
  endfunction

endpackage

// File: rtl/tick_edge.sv
module tick_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= 1'b0;
    else        sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/tmo_start_sel.sv
module tmo_start_sel
  import mtw_pkg::*;
(
  input  logic   seek_i,
  input  logic   load_i,
  input  logic   unload_i,
  input  logic   recal_i,
  output logic   any_start_o,
  output logic   long_win_o,
  output await_e await_o
);
  always_comb begin
    any_start_o = seek_i | load_i | unload_i | recal_i;
    long_win_o  = 1'b0;
    await_o     = AWAIT_SETTLE;
    if (seek_i) begin
      long_win_o = 1'b0;
    end else if (recal_i || load_i) begin
      long_win_o = 1'b1;
    end else if (unload_i) begin
      long_win_o = 1'b1;
      await_o    = AWAIT_RETRACT;
    end
  end
endmodule

// File: rtl/tmo_counter.sv
module tmo_counter
  import mtw_pkg::*;
#(
  parameter int unsigned SHORT_TICKS = 16,
  parameter int unsigned LONG_TICKS  = 225,
  parameter int unsigned CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             start_i,
  input  logic             long_win_i,
  input  await_e           await_i,
  input  logic             settled_i,
  input  logic             retracted_i,
  input  logic             tick_i,
  output logic             fault_o,
  output logic             active_o,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q, limit_q;
  logic             active_q, fault_q;
  await_e           await_q;
  logic             done_evt;

  assign done_evt = (await_q == AWAIT_SETTLE) ? settled_i : retracted_i;
  assign expire_o = active_q & ~fault_q & ~clear_i & ~start_i & ~done_evt & tick_i &
                    hits_terminal(32'(count_q), 32'(limit_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      limit_q  <= CNT_W'(SHORT_TICKS);
      active_q <= 1'b0;
      fault_q  <= 1'b0;
      await_q  <= AWAIT_SETTLE;
    end else if (clear_i) begin
      count_q  <= '0;
      active_q <= 1'b0;
      fault_q  <= 1'b0;
    end else if (!fault_q) begin
      if (start_i) begin
        count_q  <= '0;
        limit_q  <= CNT_W'(window_ticks(long_win_i, SHORT_TICKS, LONG_TICKS));
        await_q  <= await_i;
        active_q <= 1'b1;
      end else if (active_q && done_evt) begin
        count_q  <= '0;
        active_q <= 1'b0;
      end else if (active_q && tick_i) begin
        count_q <= count_q + CNT_W'(1);
        if (expire_o) begin
          fault_q  <= 1'b1;
          active_q <= 1'b0;
        end
      end
    end
  end

  assign fault_o  = fault_q;
  assign active_o = active_q;
  assign count_o  = count_q;
endmodule

// File: rtl/mech_timeout_wdog.sv
module mech_timeout_wdog
  import mtw_pkg::*;
#(
  parameter int unsigned SHORT_TICKS = 16,
  parameter int unsigned LONG_TICKS  = 225,
  localparam int unsigned CNT_W      = $clog2(LONG_TICKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  input  logic start_seek,
  input  logic start_load,
  input  logic start_unload,
  input  logic start_recal,
  input  logic settled_i,
  input  logic retracted_i,
  input  logic por_start,
  input  logic run_sw,
  output logic fault_n,
  output logic fault_led,
  output logic shutdown_req
);
  logic             tick_evt, run_rise, clear_evt;
  logic             any_start, long_win;
  await_e           await_sel;
  logic             fault_q, cycle_active, expire_evt;
  logic [CNT_W-1:0] cnt;

  tick_edge u_tick (.clk(clk), .rst_n(rst_n), .sig_i(tick_in), .rise_o(tick_evt));
  tick_edge u_run  (.clk(clk), .rst_n(rst_n), .sig_i(run_sw),  .rise_o(run_rise));

  assign clear_evt = por_start | run_rise;

  tmo_start_sel u_sel (
    .seek_i(start_seek), .load_i(start_load), .unload_i(start_unload),
    .recal_i(start_recal), .any_start_o(any_start), .long_win_o(long_win),
    .await_o(await_sel)
  );

  tmo_counter #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear_i(clear_evt), .start_i(any_start),
    .long_win_i(long_win), .await_i(await_sel), .settled_i(settled_i),
    .retracted_i(retracted_i), .tick_i(tick_evt), .fault_o(fault_q),
    .active_o(cycle_active), .count_o(cnt), .expire_o(expire_evt)
  );

  assign fault_n      = ~fault_q;
  assign fault_led    = fault_q;
  assign shutdown_req = fault_q;
endmodule

// File: rtl/mtw_checker.sv
module mtw_checker #(
  parameter int unsigned LONG_TICKS = 225,
  parameter int unsigned CNT_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear_evt,
  input logic             tick_evt,
  input logic             expire_evt,
  input logic             cycle_active,
  input logic             fault_n,
  input logic             fault_led,
  input logic             shutdown_req,
  input logic [CNT_W-1:0] cnt
);
  // R9
  fault_outputs_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_n == !fault_led) && (shutdown_req == fault_led));

  // R10
  fault_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_led && !clear_evt) |=> fault_led);

  // R11
  clear_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> (fault_n && !cycle_active));

  // R7
  fault_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_led) |-> ($past(cycle_active) && $past(tick_evt) && $past(expire_evt)));

  // R3
  count_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= LONG_TICKS);
endmodule

bind mech_timeout_wdog mtw_checker #(.LONG_TICKS(LONG_TICKS), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_evt(clear_evt), .tick_evt(tick_evt),
  .expire_evt(expire_evt), .cycle_active(cycle_active), .fault_n(fault_n),
  .fault_led(fault_led), .shutdown_req(shutdown_req), .cnt(cnt)
);

// File: tb/mech_timeout_wdog_bench.sv
`timescale 1ns/1ps
module mech_timeout_wdog_bench;
  localparam int SHORT = 16;
  localparam int LONG  = 225;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_in = 0, start_seek = 0, start_load = 0, start_unload = 0, start_recal = 0;
  logic settled_i = 0, retracted_i = 0, por_start = 0, run_sw = 0;
  logic fault_n, fault_led, shutdown_req;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mech_timeout_wdog u_mech_timeout_wdog (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .start_seek(start_seek),
    .start_load(start_load), .start_unload(start_unload), .start_recal(start_recal),
    .settled_i(settled_i), .retracted_i(retracted_i), .por_start(por_start),
    .run_sw(run_sw), .fault_n(fault_n), .fault_led(fault_led), .shutdown_req(shutdown_req)
  );

  // Operation codes: 0 seek, 1 load, 2 unload, 3 recal. Cancel: 0 none, 1 settle, 2 retract.
  localparam int NV = 12;
  localparam int V_OP  [NV] = '{0, 0, 1, 1, 3, 2, 0, 3, 2, 2, 0, 1};
  localparam int V_CAN [NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 2, 1, 2, 1};
  localparam int V_N1  [NV] = '{SHORT-1, SHORT, LONG-1, LONG, LONG, LONG, SHORT-1, 200, LONG-1, 100, 10, 0};
  localparam int V_N2  [NV] = '{0, 0, 0, 0, 0, 0, 20, 100, 50, LONG-100, SHORT-10, 230};
  localparam int V_EXP [NV] = '{0, 1, 0, 1, 1, 1, 0, 0, 0, 1, 1, 0};
  localparam string V_REQ [NV] = '{"R2", "R2", "R3", "R3", "R3", "R3", "R4", "R4", "R5", "R5", "R5", "R4"};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected fault state: all three outputs agree with it (R9)
  task automatic check_fault(input string req, input int exp);
    check(fault_led == exp[0] && fault_n == !exp[0] && shutdown_req == exp[0],
          req, int'(fault_led), exp);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n, input int width);
    for (int i = 0; i < n; i++) begin
      tick_in = 1'b1; cyc(width);
      tick_in = 1'b0; cyc(2);
    end
  endtask

  task automatic start_op(input int op);
    case (op)
      0: start_seek = 1'b1;
      1: start_load = 1'b1;
      2: start_unload = 1'b1;
      default: start_recal = 1'b1;
    endcase
    cyc(1);
    start_seek = 0; start_load = 0; start_unload = 0; start_recal = 0;
  endtask

  task automatic pulse_por();
    por_start = 1'b1; cyc(1); por_start = 1'b0; cyc(1);
  endtask

  task automatic cancel(input int c);
    if (c == 1) settled_i = 1'b1;
    if (c == 2) retracted_i = 1'b1;
    cyc(1);
    settled_i = 1'b0; retracted_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check_fault("R1 reset", 0);
    rst_n = 1'b1;
    cyc(2);
    check_fault("R1 after release", 0);

    for (int v = 0; v < NV; v++) begin
      pulse_por();
      start_op(V_OP[v]);
      ticks(V_N1[v], 2);
      if (V_CAN[v] != 0) begin
        cancel(V_CAN[v]);
        ticks(V_N2[v], 2);
      end
      check_fault(V_REQ[v], V_EXP[v]);
    end

    // R6: wide tick pulses counted once each
    pulse_por(); start_op(0); ticks(SHORT-1, 5);
    check_fault("R6 wide ticks short", 0);
    ticks(1, 7);
    check_fault("R6 wide ticks expire", 1);

    // R7: idle ticks do nothing
    pulse_por(); ticks(LONG + 20, 2);
    check_fault("R7 idle ticks", 0);

    // R8: restart with new window
    pulse_por(); start_op(1); ticks(200, 2); start_op(0); ticks(SHORT-1, 2);
    check_fault("R8 restart before limit", 0);
    ticks(1, 2);
    check_fault("R8 restart expire", 1);

    // R10: fault holds against stimulus
    cancel(1); cancel(2); start_op(0); ticks(5, 2);
    check_fault("R10 latched", 1);

    // R11: run rise clears, held run does not clear again, por clears
    run_sw = 1'b1; cyc(2);
    check_fault("R11 run rise", 0);
    start_op(0); ticks(SHORT, 2);
    check_fault("R11 refault", 1);
    cyc(5);
    check_fault("R11 held run", 1);
    pulse_por();
    check_fault("R11 por clear", 0);
    start_op(3); ticks(LONG, 2);
    check_fault("R11 normal after clear", 1);
    run_sw = 1'b0; pulse_por();

    // R12: simultaneous starts
    start_seek = 1; start_load = 1; cyc(1); start_seek = 0; start_load = 0;
    ticks(SHORT, 2);
    check_fault("R12 seek wins", 1);
    pulse_por();
    start_load = 1; start_unload = 1; cyc(1); start_load = 0; start_unload = 0;
    cancel(1); ticks(LONG + 5, 2);
    check_fault("R12 load over unload", 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule